// File: doc/BRIEF.md
# Microsequencer with Bit-OR Multiway Dispatch

This block forms the next-address logic of a microprogrammed control unit. It holds a 9-bit micro-program counter. Written in octal, that counter is three digits. On every clock edge the counter loads a new value. A four-way selector picks the candidate: the counter plus one, the counter itself, a start address decoded from the opcode field of the instruction register, or the branch-address field of the current microinstruction. When the selector picks the branch field, one of five branch conditions must hold, or the sequence falls through to the next address.

After the selector, a bit-OR stage may force some address bits to one, based on the addressing-mode bits of the instruction register (bits 10..8). One enable spreads the four mode classes and the register-indirect case across the middle octal digit. A second enable chooses between two adjacent entries, for direct and indirect operand fetch. Each dispatch therefore costs a single microinstruction. A microroutine ends with an unconditional branch to address 000, which is where the fetch routine starts.

Top module: `useq_top`

## Requirements
- R1: A synchronous active-high `rst` loads the counter with 000 on the next rising edge.
- R2: Select code 00 loads the counter plus one. From 511 the counter wraps to 000.
- R3: Select code 01 loads the decoded start address. If opcode bits 15..11 equal 00001, the start address is octal 101. For any other opcode k, it is 256 + 8·k.
- R4: Select code 10 holds the counter value.
- R5: Select code 11 with enable bit 0 (always) set loads `br_addr_i`. Branching to 000 returns to the fetch routine.
- R6: The other enable bits are conditional. Bit 1 is taken when Z is 0, bit 2 when Z is 1, bit 3 when N is 0, and bit 4 when N is 1. The branch is taken if any enabled condition holds.
- R7: If select code 11 has no enabled condition holding, the counter loads the counter plus one.
- R8: When `or_mode_i` is 1, next-address bits 5 and 4 are ORed with IR bits 10 and 9.
- R9: When `or_mode_i` is 1, next-address bit 3 is ORed with (not IR10) and (not IR9) and IR8. Register-indirect mode then dispatches to octal 111, while register-direct mode dispatches to 101.
- R10: When `or_ind_i` is 1, next-address bit 0 is ORed with (not IR8). A branch to octal 170 lands on 171 when the mode is direct.
- R11: The OR stage follows the selector, so it acts on every source, including hold and step. With both enables at 0, the selected address passes through unchanged. The stage can only set bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_i | input | 2 | Next-address source: 00 step, 01 decode, 10 hold, 11 branch |
| br_en_i | input | 5 | Branch condition enables: always, not-zero, zero, not-negative, negative |
| or_ind_i | input | 1 | Enable for the direct/indirect OR into bit 0 |
| or_mode_i | input | 1 | Enable for the mode OR into bits 5..3 |
| flag_z_i | input | 1 | Zero status flag |
| flag_n_i | input | 1 | Negative status flag |
| ir_i | input | 16 | Instruction register |
| br_addr_i | input | 9 | Branch-address field of the microinstruction |
| upc_o | output | 9 | Micro-program counter, which is the control-store address |

## Verification
The bench runs the dispatch over all eight mode codes:
- Mode 001 must reach 111. A design that decodes bit 3 from IR8 alone would also set it for mode 011.
- A design that leaves the mode OR out of the register modes would send register-indirect to 101.

Branching to 170 with each value of IR8, and with the indirect enable both on and off, catches an inverted IR8 term and an enable that is ignored. Each conditional enable is tested with its flag in both states, which catches swapped conditions and branches taken when the condition fails. The bench also tests wrap from 511 and applies the OR stage to a held address. These cases expose a counter with the wrong width and an OR stage placed before the selector.

// File: rtl/useq_pkg.sv
package useq_pkg;

    typedef enum logic [1:0] {
        SRC_STEP   = 2'b00,
        SRC_DECODE = 2'b01,
        SRC_HOLD   = 2'b10,
        SRC_BRANCH = 2'b11
    } nxt_src_e;

    localparam int NUM_COND  = 5;
    localparam int COND_ALW  = 0;
    localparam int COND_NZ   = 1;
    localparam int COND_Z    = 2;
    localparam int COND_NN   = 3;
    localparam int COND_N    = 4;

endpackage

// File: rtl/useq_decode.sv
module useq_decode #(
    parameter int ADDR_W        = 9,
    parameter int OP_W          = 5,
    parameter logic [OP_W-1:0]  DISPATCH_OP   = 5'd1,
    parameter logic [ADDR_W-1:0] DISPATCH_ADDR = 9'o101
) (
    input  logic [OP_W-1:0]   op_i,
    output logic [ADDR_W-1:0] start_o
);
    localparam int PAD_W = ADDR_W - 1 - OP_W;

    logic [ADDR_W-1:0] generic_d;

    always_comb begin
        generic_d = ADDR_W'({1'b1, op_i}) << PAD_W;
        start_o   = (op_i == DISPATCH_OP) ? DISPATCH_ADDR : generic_d;
    end
endmodule

// File: rtl/useq_nextsel.sv
module useq_nextsel
    import useq_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic [ADDR_W-1:0]   upc_i,
    input  logic [ADDR_W-1:0]   dec_addr_i,
    input  logic [ADDR_W-1:0]   br_addr_i,
    input  logic [1:0]          sel_i,
    input  logic [NUM_COND-1:0] br_en_i,
    input  logic                flag_z_i,
    input  logic                flag_n_i,
    output logic [ADDR_W-1:0]   addr_o,
    output logic                taken_o
);
    logic [NUM_COND-1:0] cond_d;
    logic [ADDR_W-1:0]   inc_d;

    always_comb begin
        cond_d           = '0;
        cond_d[COND_ALW] = 1'b1;
        cond_d[COND_NZ]  = ~flag_z_i;
        cond_d[COND_Z]   = flag_z_i;
        cond_d[COND_NN]  = ~flag_n_i;
        cond_d[COND_N]   = flag_n_i;
        taken_o          = |(br_en_i & cond_d);
        inc_d            = upc_i + ADDR_W'(1);
        unique case (nxt_src_e'(sel_i))
            SRC_STEP:   addr_o = inc_d;
            SRC_DECODE: addr_o = dec_addr_i;
            SRC_HOLD:   addr_o = upc_i;
            SRC_BRANCH: addr_o = taken_o ? br_addr_i : inc_d;
            default:    addr_o = inc_d;
        endcase
    end
endmodule

// File: rtl/useq_bitor.sv
module useq_bitor #(
    parameter int ADDR_W   = 9,
    parameter int MODE_LSB = 4,
    parameter int REGI_BIT = 3,
    parameter int IND_BIT  = 0
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [2:0]        mode_i,
    input  logic              or_mode_i,
    input  logic              or_ind_i,
    output logic [ADDR_W-1:0] addr_o
);
    logic [ADDR_W-1:0] mask_d;

    always_comb begin
        mask_d = '0;
        if (or_mode_i) begin
            mask_d[MODE_LSB+1] = mode_i[2];
            mask_d[MODE_LSB]   = mode_i[1];
            mask_d[REGI_BIT]   = ~mode_i[2] & ~mode_i[1] & mode_i[0];
        end
        if (or_ind_i) begin
            mask_d[IND_BIT] = ~mode_i[0];
        end
        addr_o = addr_i | mask_d;
    end

    // R11: the stage may only set bits of the selected address
    always_comb begin
        if (!$isunknown(addr_i) && !$isunknown(addr_o)) begin
            p_only_sets_r11: assert ((addr_o & addr_i) == addr_i);
        end
    end
endmodule

// File: rtl/useq_top.sv
module useq_top
    import useq_pkg::*;
#(
    parameter int ADDR_W   = 9,
    parameter int IR_W     = 16,
    parameter int OP_W     = 5,
    parameter int MODE_LSB = 8,
    parameter logic [OP_W-1:0]   DISPATCH_OP   = 5'd1,
    parameter logic [ADDR_W-1:0] DISPATCH_ADDR = 9'o101
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          sel_i,
    input  logic [NUM_COND-1:0] br_en_i,
    input  logic                or_ind_i,
    input  logic                or_mode_i,
    input  logic                flag_z_i,
    input  logic                flag_n_i,
    input  logic [IR_W-1:0]     ir_i,
    input  logic [ADDR_W-1:0]   br_addr_i,
    output logic [ADDR_W-1:0]   upc_o
);
    localparam int OP_LSB = IR_W - OP_W;

    typedef struct packed {
        logic [ADDR_W-1:0] upc;
    } seq_state_t;

    seq_state_t        st_d, st_q;
    logic [ADDR_W-1:0] dec_addr;
    logic [ADDR_W-1:0] sel_addr;
    logic [ADDR_W-1:0] adj_addr;
    logic              taken;

    useq_decode #(
        .ADDR_W(ADDR_W), .OP_W(OP_W),
        .DISPATCH_OP(DISPATCH_OP), .DISPATCH_ADDR(DISPATCH_ADDR)
    ) u_decode (
        .op_i   (ir_i[IR_W-1:OP_LSB]),
        .start_o(dec_addr)
    );

    useq_nextsel #(.ADDR_W(ADDR_W)) u_nextsel (
        .upc_i     (st_q.upc),
        .dec_addr_i(dec_addr),
        .br_addr_i (br_addr_i),
        .sel_i     (sel_i),
        .br_en_i   (br_en_i),
        .flag_z_i  (flag_z_i),
        .flag_n_i  (flag_n_i),
        .addr_o    (sel_addr),
        .taken_o   (taken)
    );

    useq_bitor #(.ADDR_W(ADDR_W)) u_bitor (
        .addr_i   (sel_addr),
        .mode_i   (ir_i[MODE_LSB+2:MODE_LSB]),
        .or_mode_i(or_mode_i),
        .or_ind_i (or_ind_i),
        .addr_o   (adj_addr)
    );

    always_comb begin
        st_d     = st_q;
        st_d.upc = adj_addr;
        if (rst) begin
            st_d.upc = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign upc_o = st_q.upc;

    logic or_off;
    assign or_off = !or_ind_i && !or_mode_i;

    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (sel_i == SRC_STEP && or_off) |=> upc_o == $past(upc_o) + ADDR_W'(1));

    p_dispatch_r3: assert property (@(posedge clk) disable iff (rst)
        (sel_i == SRC_DECODE && or_off && ir_i[IR_W-1:OP_LSB] == DISPATCH_OP)
        |=> upc_o == DISPATCH_ADDR);

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (sel_i == SRC_HOLD && or_off) |=> $stable(upc_o));

    p_branch_r5: assert property (@(posedge clk) disable iff (rst)
        (sel_i == SRC_BRANCH && br_en_i[COND_ALW] && or_off)
        |=> upc_o == $past(br_addr_i));

    p_fallthru_r7: assert property (@(posedge clk) disable iff (rst)
        (sel_i == SRC_BRANCH && br_en_i == '0 && or_off)
        |=> upc_o == $past(upc_o) + ADDR_W'(1));

    p_taken_r6: assert property (@(posedge clk) disable iff (rst)
        (sel_i == SRC_BRANCH && br_en_i == (NUM_COND'(1) << COND_Z) && flag_z_i && or_off)
        |-> taken);
endmodule

// File: tb/sim_useq_top.sv
module sim_useq_top;
    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] sel;
    logic [4:0] en;
    logic       ori, orm, fz, fn;
    logic [15:0] ir;
    logic [8:0] br;
    logic [8:0] upc;

    always #5 clk = ~clk;

    useq_top u0 (
        .clk(clk), .rst(rst), .sel_i(sel), .br_en_i(en),
        .or_ind_i(ori), .or_mode_i(orm), .flag_z_i(fz), .flag_n_i(fn),
        .ir_i(ir), .br_addr_i(br), .upc_o(upc)
    );

    typedef struct { logic [8:0] exp; string req; } item_t;
    item_t q[$];
    int checks = 0;
    int fails = 0;
    logic [8:0] model_pc = 9'd0;
    bit done = 1'b0;

    function automatic logic [15:0] mk_ir(input logic [4:0] op, input logic [2:0] mode);
        return {op, mode, 4'h3, 4'h5};
    endfunction

    function automatic logic [8:0] ref_next(
        input logic [8:0] pc, input logic [1:0] s, input logic [4:0] e,
        input logic z, input logic n, input logic oi, input logic om,
        input logic [15:0] ins, input logic [8:0] b);
        logic [8:0] a;
        logic tk;
        tk = e[0] | (e[1] & !z) | (e[2] & z) | (e[3] & !n) | (e[4] & n);
        case (s)
            2'b00: a = pc + 9'd1;
            2'b01: a = (ins[15:11] == 5'd1) ? 9'o101 : 9'(256 + 8 * int'(ins[15:11]));
            2'b10: a = pc;
            default: a = tk ? b : pc + 9'd1;
        endcase
        if (om) begin
            a[5] = a[5] | ins[10];
            a[4] = a[4] | ins[9];
            a[3] = a[3] | (!ins[10] & !ins[9] & ins[8]);
        end
        if (oi) a[0] = a[0] | !ins[8];
        return a;
    endfunction

    task automatic apply(input string req, input logic [1:0] s, input logic [4:0] e,
                         input logic z, input logic n, input logic oi, input logic om,
                         input logic [15:0] ins, input logic [8:0] b);
        item_t it;
        @(negedge clk);
        rst = 1'b0; sel = s; en = e; fz = z; fn = n; ori = oi; orm = om; ir = ins; br = b;
        model_pc = ref_next(model_pc, s, e, z, n, oi, om, ins, b);
        it.exp = model_pc; it.req = req;
        q.push_back(it);
    endtask

    task automatic do_reset();
        item_t it;
        @(negedge clk);
        rst = 1'b1; sel = 2'b00; en = '0; ori = 0; orm = 0;
        model_pc = 9'd0;
        it.exp = 9'd0; it.req = "R1";
        q.push_back(it);
    endtask

    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            checks++;
            if (upc !== it.exp) begin
                fails++;
                $display("FAIL %s: upc actual %o expected %o", it.req, upc, it.exp);
            end
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; sel = 0; en = 0; ori = 0; orm = 0; fz = 0; fn = 0; ir = 0; br = 0;
        do_reset(); do_reset();
        // R2 stepping
        apply("R2", 2'b00, 5'd0, 0, 0, 0, 0, 16'h0, 9'd0);
        apply("R2", 2'b00, 5'd0, 0, 0, 0, 0, 16'h0, 9'd0);
        // R3 / R8 / R9 dispatch over all modes
        for (int m = 0; m < 8; m++) begin
            apply(m == 1 ? "R9" : "R8", 2'b01, 5'd0, 0, 0, 0, 1, mk_ir(5'd1, 3'(m)), 9'd0);
        end
        apply("R11", 2'b01, 5'd0, 0, 0, 0, 0, mk_ir(5'd1, 3'b110), 9'd0);
        apply("R3", 2'b01, 5'd0, 0, 0, 0, 0, mk_ir(5'd5, 3'b000), 9'd0);
        apply("R3", 2'b01, 5'd0, 0, 0, 0, 0, mk_ir(5'd31, 3'b000), 9'd0);
        // R4 hold
        apply("R4", 2'b10, 5'd0, 0, 0, 0, 0, 16'h0, 9'd0);
        apply("R4", 2'b10, 5'd0, 0, 0, 0, 0, 16'h0, 9'd0);
        // R10 direct/indirect split
        apply("R10", 2'b11, 5'b00001, 0, 0, 1, 0, mk_ir(5'd1, 3'b010), 9'o170);
        apply("R10", 2'b11, 5'b00001, 0, 0, 1, 0, mk_ir(5'd1, 3'b011), 9'o170);
        apply("R11", 2'b11, 5'b00001, 0, 0, 0, 0, mk_ir(5'd1, 3'b010), 9'o170);
        // R11 OR on held address
        apply("R11", 2'b10, 5'd0, 0, 0, 1, 0, mk_ir(5'd1, 3'b000), 9'd0);
        // R6 / R7 conditions
        apply("R6", 2'b11, 5'b00010, 0, 0, 0, 0, 16'h0, 9'o040);
        apply("R7", 2'b11, 5'b00010, 1, 0, 0, 0, 16'h0, 9'o300);
        apply("R6", 2'b11, 5'b00100, 1, 0, 0, 0, 16'h0, 9'o200);
        apply("R7", 2'b11, 5'b00100, 0, 0, 0, 0, 16'h0, 9'o300);
        apply("R6", 2'b11, 5'b01000, 0, 0, 0, 0, 16'h0, 9'o250);
        apply("R7", 2'b11, 5'b01000, 0, 1, 0, 0, 16'h0, 9'o300);
        apply("R6", 2'b11, 5'b10000, 0, 1, 0, 0, 16'h0, 9'o333);
        apply("R7", 2'b11, 5'b10000, 0, 0, 0, 0, 16'h0, 9'o300);
        apply("R6", 2'b11, 5'b10010, 1, 1, 0, 0, 16'h0, 9'o055);
        apply("R7", 2'b11, 5'b00000, 1, 1, 0, 0, 16'h0, 9'o300);
        // R2 wrap
        apply("R5", 2'b11, 5'b00001, 0, 0, 0, 0, 16'h0, 9'd511);
        apply("R2", 2'b00, 5'd0, 0, 0, 0, 0, 16'h0, 9'd0);
        apply("R2", 2'b00, 5'd0, 0, 0, 0, 0, 16'h0, 9'd0);
        // R5 return to fetch
        apply("R5", 2'b11, 5'b00001, 0, 0, 0, 0, 16'h0, 9'o173);
        apply("R5", 2'b11, 5'b00001, 0, 0, 0, 0, 16'h0, 9'o000);
        apply("R2", 2'b00, 5'd0, 0, 0, 0, 0, 16'h0, 9'd0);
        // R1 mid-run reset
        do_reset();
        apply("R2", 2'b00, 5'd0, 0, 0, 0, 0, 16'h0, 9'd0);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule